// File: doc/BRIEF.md
# Ethernet Transmit Descriptor Walker

This block walks a circular ring of transmit buffer descriptors held in a simple synchronous memory. Each descriptor is two consecutive 32-bit words: word 0 (even address) holds the data address of a buffer, and word 1 (odd address) holds the control/status bits. Starting from a pointer given with a go strobe, the walker reads each descriptor and forwards the buffer's data address and byte count to a downstream fetch unit. It keeps doing this until it reaches the buffer marked as the last of a frame.

It then waits for the transmitter to report the end of that frame. After that it performs a read-modify-write on the control word of the frame's first descriptor: it either hands that descriptor back to software by setting the ownership bit, or records the failure cause. After a success it continues with the next frame. It stops and shows idle when the next frame start is still owned by software, and it stops with an error flag after a failure.

The memory port has single-cycle read latency: data requested in one cycle is on `memRdata` in the next cycle. Descriptor pointers are word addresses and must be even.

Top module: `txDescWalker`

## Requirements
- R1: After reset the block is idle (`idle`=1), `errFlag`=0, and `memRd`, `memWr` and `fetchValid` are all 0.
- R2: On `goStrobe` while idle, the walker loads `startPtr`. For each descriptor it reads the control word (pointer+1), then the address word (pointer). It then pulses `fetchValid` for one cycle with `fetchAddr` = address word and `fetchLen` = control bits 10:0. `fetchLast` = control bit 15.
- R3: If control bit 31 (ownership, 1 = owned by software) is set on the descriptor where a frame would start, the walker returns to idle. It raises no error, writes nothing and issues no fetch.
- R4: Buffers of a frame are fetched in ring order, with the pointer advancing by 2 words per descriptor. No other fetches are issued.
- R5: After a descriptor whose control bit 30 (wrap) is set, the next descriptor is read at `listBase`.
- R6: `fetchNoCrc` is 1 only when the buffer has both bit 16 (no-CRC) and bit 15 (last) set. Bit 16 on a non-last buffer has no effect.
- R7: After `txDone` with no error, the walker sets bit 31 in the first descriptor's control word and leaves all its other bits unchanged. The control words of the frame's later descriptors are not written. It then continues with the next descriptor.
- R8: `txRetryErr` sampled with `txDone` sets bit 29 in the first descriptor's control word. Bit 31 is left clear. The walker goes idle with `errFlag`=1.
- R9: `txUnderrun` sampled with `txDone` sets bit 28 in the first descriptor's control word, with bit 31 left clear and `errFlag`=1.
- R10: An owned descriptor met partway through a frame sets bits 28 and 27 in the first descriptor's control word without waiting for the transmitter. The walker then goes idle with `errFlag`=1.
- R11: `goStrobe` is ignored while the walker is busy. A `goStrobe` accepted while idle clears `errFlag`, and `errFlag` is only ever 1 while idle.
- R12: `memRd` and `memWr` are never 1 in the same cycle. Every write goes to the address read in the cycle just before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| goStrobe | input | 1 | Start walking from `startPtr` (when idle) |
| startPtr | input | ADDR_W | Word address of the first descriptor to process |
| listBase | input | ADDR_W | Word address of the ring's first descriptor (wrap target) |
| memAddr | output | ADDR_W | Memory word address |
| memRd | output | 1 | Memory read request; data returns next cycle |
| memWr | output | 1 | Memory write strobe |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data |
| fetchValid | output | 1 | One-cycle buffer fetch request |
| fetchAddr | output | 32 | Buffer data address |
| fetchLen | output | 11 | Buffer length in bytes |
| fetchLast | output | 1 | Buffer is the frame's last |
| fetchNoCrc | output | 1 | Frame is sent without CRC |
| txDone | input | 1 | Transmitter finished the current frame |
| txRetryErr | input | 1 | Retry limit exceeded (valid with `txDone`) |
| txUnderrun | input | 1 | Transmit underrun (valid with `txDone`) |
| idle | output | 1 | Walker stopped |
| errFlag | output | 1 | Last stop was caused by a frame error |

## Verification
Assertions check on every cycle that:
- the memory port never reads and writes together;
- each write lands on the address read just before it;
- each fetch follows a memory read;
- nothing moves on the port while idle;
- the error flag only shows while idle.

Only the bench scenarios can show the descriptor semantics, using a memory model and a transmitter model:
- which descriptor is written back, and which bits;
- whether the wrap bit actually redirects the walk;
- that no-CRC is honoured only on the last buffer;
- that trap descriptors placed past a stop point are never fetched.

// File: rtl/txdw_pkg.sv
package txdw_pkg;

  localparam int OWN_BIT     = 31;
  localparam int WRAP_BIT    = 30;
  localparam int RETRY_BIT   = 29;
  localparam int UNDER_BIT   = 28;
  localparam int EXHAUST_BIT = 27;
  localparam int NOCRC_BIT   = 16;
  localparam int LAST_BIT    = 15;
  localparam int LEN_W       = 11;
  localparam int WORD_W      = 32;

  typedef enum logic [1:0] {
    SEL_CTL = 2'd0,
    SEL_ADR = 2'd1,
    SEL_WB  = 2'd2
  } addrSel_e;

  typedef struct packed {
    addrSel_e sel;
    logic     rd;
    logic     wr;
    logic     loadStart;
    logic     captureCtl;
    logic     markFirst;
    logic     advance;
    logic     issue;
    logic     latchTx;
    logic     markExhaust;
    logic     setErr;
    logic     clrErr;
  } dpCtl_t;

endpackage

// File: rtl/txdw_ctrl.sv
module txdw_ctrl
  import txdw_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   goStrobe,
  input  logic   rdUsed,
  input  logic   ctlLast,
  input  logic   wbErr,
  input  logic   txDone,
  output dpCtl_t ctl,
  output logic   idle
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDCTL, ST_CHKCTL, ST_RDADR, ST_ISSUE, ST_WAITTX, ST_RDWB, ST_WRWB
  } state_e;

  state_e state, stateNxt;
  logic   inFrame;

  always_comb begin
    ctl      = '0;
    ctl.sel  = SEL_CTL;
    stateNxt = state;
    case (state)
      ST_IDLE: if (goStrobe) begin
        ctl.loadStart = 1'b1;
        ctl.clrErr    = 1'b1;
        stateNxt      = ST_RDCTL;
      end
      ST_RDCTL: begin
        ctl.rd   = 1'b1;
        stateNxt = ST_CHKCTL;
      end
      ST_CHKCTL: begin
        ctl.captureCtl = 1'b1;
        if (rdUsed) begin
          if (inFrame) begin
            ctl.markExhaust = 1'b1;
            stateNxt        = ST_RDWB;
          end else begin
            stateNxt = ST_IDLE;
          end
        end else begin
          ctl.markFirst = !inFrame;
          stateNxt      = ST_RDADR;
        end
      end
      ST_RDADR: begin
        ctl.rd   = 1'b1;
        ctl.sel  = SEL_ADR;
        stateNxt = ST_ISSUE;
      end
      ST_ISSUE: begin
        ctl.issue   = 1'b1;
        ctl.advance = 1'b1;
        stateNxt    = ctlLast ? ST_WAITTX : ST_RDCTL;
      end
      ST_WAITTX: if (txDone) begin
        ctl.latchTx = 1'b1;
        stateNxt    = ST_RDWB;
      end
      ST_RDWB: begin
        ctl.rd   = 1'b1;
        ctl.sel  = SEL_WB;
        stateNxt = ST_WRWB;
      end
      ST_WRWB: begin
        ctl.wr  = 1'b1;
        ctl.sel = SEL_WB;
        if (wbErr) begin
          ctl.setErr = 1'b1;
          stateNxt   = ST_IDLE;
        end else begin
          stateNxt = ST_RDCTL;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      inFrame <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctl.loadStart || ctl.latchTx || ctl.markExhaust) inFrame <= 1'b0;
      else if (ctl.markFirst)                             inFrame <= 1'b1;
    end
  end

  assign idle = (state == ST_IDLE);

  // R1: while stopped the memory port and fetch interface stay quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (!ctl.rd && !ctl.wr && !ctl.issue));

  // R11: a go pulse while busy never reloads the start pointer
  a_r11_go_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (goStrobe && !idle) |-> !ctl.loadStart);

endmodule

// File: rtl/txdw_dpath.sv
module txdw_dpath
  import txdw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic [ADDR_W-1:0]   startPtr,
  input  logic [ADDR_W-1:0]   listBase,
  input  logic [WORD_W-1:0]   memRdata,
  input  logic                txRetryErr,
  input  logic                txUnderrun,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRd,
  output logic                memWr,
  output logic [WORD_W-1:0]   memWdata,
  output logic                fetchValid,
  output logic [WORD_W-1:0]   fetchAddr,
  output logic [LEN_W-1:0]    fetchLen,
  output logic                fetchLast,
  output logic                fetchNoCrc,
  output logic                rdUsed,
  output logic                ctlLast,
  output logic                wbErr,
  output logic                errFlag
);

  localparam logic [ADDR_W-1:0] CTL_OFS  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DESC_INC = ADDR_W'(2);

  logic [ADDR_W-1:0] curPtr, firstPtr;
  logic [WORD_W-1:0] ctlReg;
  logic              stRetry, stUnder, stExhaust;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr    <= '0;
      firstPtr  <= '0;
      ctlReg    <= '0;
      stRetry   <= 1'b0;
      stUnder   <= 1'b0;
      stExhaust <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (ctl.loadStart)   curPtr <= startPtr;
      else if (ctl.advance) curPtr <= ctlReg[WRAP_BIT] ? listBase : curPtr + DESC_INC;
      if (ctl.markFirst)  firstPtr <= curPtr;
      if (ctl.captureCtl) ctlReg   <= memRdata;
      if (ctl.latchTx) begin
        stRetry   <= txRetryErr;
        stUnder   <= txUnderrun;
        stExhaust <= 1'b0;
      end else if (ctl.markExhaust) begin
        stRetry   <= 1'b0;
        stUnder   <= 1'b1;
        stExhaust <= 1'b1;
      end
      if (ctl.clrErr)      errFlag <= 1'b0;
      else if (ctl.setErr) errFlag <= 1'b1;
    end
  end

  always_comb begin
    case (ctl.sel)
      SEL_ADR: memAddr = curPtr;
      SEL_WB:  memAddr = firstPtr + CTL_OFS;
      default: memAddr = curPtr + CTL_OFS;
    endcase
  end

  assign memRd = ctl.rd;
  assign memWr = ctl.wr;
  assign wbErr = stRetry | stUnder | stExhaust;

  always_comb begin
    memWdata              = memRdata;
    memWdata[OWN_BIT]     = memRdata[OWN_BIT] | !wbErr;
    memWdata[RETRY_BIT]   = memRdata[RETRY_BIT] | stRetry;
    memWdata[UNDER_BIT]   = memRdata[UNDER_BIT] | stUnder;
    memWdata[EXHAUST_BIT] = memRdata[EXHAUST_BIT] | stExhaust;
  end

  assign rdUsed     = memRdata[OWN_BIT];
  assign ctlLast    = ctlReg[LAST_BIT];
  assign fetchValid = ctl.issue;
  assign fetchAddr  = memRdata;
  assign fetchLen   = ctlReg[LEN_W-1:0];
  assign fetchLast  = ctlReg[LAST_BIT];
  assign fetchNoCrc = ctl.issue & ctlReg[LAST_BIT] & ctlReg[NOCRC_BIT];

  // R12: single operation per cycle on the memory port
  a_r12_no_rd_wr: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R12: a write is the second half of a read-modify-write on one address
  a_r12_rmw_same_addr: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> ($past(memRd) && memAddr == $past(memAddr)));

  // R2: a fetch request always uses data read in the previous cycle
  a_r2_fetch_after_read: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> $past(memRd));

endmodule

// File: rtl/txDescWalker.sv
module txDescWalker
  import txdw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              goStrobe,
  input  logic [ADDR_W-1:0] startPtr,
  input  logic [ADDR_W-1:0] listBase,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              fetchValid,
  output logic [31:0]       fetchAddr,
  output logic [10:0]       fetchLen,
  output logic              fetchLast,
  output logic              fetchNoCrc,
  input  logic              txDone,
  input  logic              txRetryErr,
  input  logic              txUnderrun,
  output logic              idle,
  output logic              errFlag
);

  dpCtl_t ctl;
  logic   rdUsed, ctlLast, wbErr;

  txdw_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .goStrobe (goStrobe),
    .rdUsed   (rdUsed),
    .ctlLast  (ctlLast),
    .wbErr    (wbErr),
    .txDone   (txDone),
    .ctl      (ctl),
    .idle     (idle)
  );

  txdw_dpath #(.ADDR_W(ADDR_W)) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .startPtr   (startPtr),
    .listBase   (listBase),
    .memRdata   (memRdata),
    .txRetryErr (txRetryErr),
    .txUnderrun (txUnderrun),
    .memAddr    (memAddr),
    .memRd      (memRd),
    .memWr      (memWr),
    .memWdata   (memWdata),
    .fetchValid (fetchValid),
    .fetchAddr  (fetchAddr),
    .fetchLen   (fetchLen),
    .fetchLast  (fetchLast),
    .fetchNoCrc (fetchNoCrc),
    .rdUsed     (rdUsed),
    .ctlLast    (ctlLast),
    .wbErr      (wbErr),
    .errFlag    (errFlag)
  );

  // R11: the error indication is only presented while stopped
  a_r11_err_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> idle);

endmodule

// File: tb/test_txDescWalker.sv
module test_txDescWalker;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          goStrobe = 1'b0;
  logic [AW-1:0] startPtr = '0;
  logic [AW-1:0] listBase = '0;
  logic [AW-1:0] memAddr;
  logic          memRd, memWr;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata;
  logic          fetchValid, fetchLast, fetchNoCrc;
  logic [31:0]   fetchAddr;
  logic [10:0]   fetchLen;
  logic          txDone = 1'b0, txRetryErr = 1'b0, txUnderrun = 1'b0;
  logic          idle, errFlag;

  logic [31:0]   mem [256];
  logic          tbWr = 1'b0;
  logic [AW-1:0] tbAddr = '0;
  logic [31:0]   tbData = '0;
  logic          cfgRetry = 1'b0, cfgUnder = 1'b0;
  int            checks = 0, errors = 0, rdWrClash = 0;
  bit            finished = 1'b0;

  typedef struct packed {
    logic [31:0] a;
    logic [10:0] l;
    logic        last;
    logic        nc;
  } fetchItem_t;
  fetchItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txDescWalker #(.ADDR_W(AW)) i_txDescWalker (
    .clk(clk), .rstN(rstN), .goStrobe(goStrobe), .startPtr(startPtr), .listBase(listBase),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .fetchLen(fetchLen), .fetchLast(fetchLast),
    .fetchNoCrc(fetchNoCrc), .txDone(txDone), .txRetryErr(txRetryErr), .txUnderrun(txUnderrun),
    .idle(idle), .errFlag(errFlag)
  );

  // memory model: single-cycle read latency
  always @(posedge clk) begin
    if (memRd) memRdata <= mem[memAddr];
    if (memWr) mem[memAddr] <= memWdata;
    if (tbWr)  mem[tbAddr] <= tbData;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected fetches
  always @(negedge clk) begin
    if (rstN) begin
      if (memRd && memWr) rdWrClash++;
      if (fetchValid) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected fetch actual=%h expected=none", fetchAddr);
        end else begin
          fetchItem_t e;
          e = expQ.pop_front();
          check("R2 fetch addr", fetchAddr, e.a);
          check("R2 fetch len", {21'd0, fetchLen}, {21'd0, e.l});
          check("R2 fetch last", {31'd0, fetchLast}, {31'd0, e.last});
          check("R6 fetch nocrc", {31'd0, fetchNoCrc}, {31'd0, e.nc});
        end
      end
    end
  end

  // transmitter model
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && fetchValid && fetchLast) begin
        repeat (3) @(negedge clk);
        txDone = 1'b1; txRetryErr = cfgRetry; txUnderrun = cfgUnder;
        @(negedge clk);
        txDone = 1'b0; txRetryErr = 1'b0; txUnderrun = 1'b0;
      end
    end
  end

  function automatic logic [31:0] mkCtl(input bit own, input bit wrap, input bit nocrc,
                                        input bit last, input int len);
    logic [31:0] c;
    c = '0;
    c[31] = own; c[30] = wrap; c[16] = nocrc; c[15] = last;
    c[10:0] = len[10:0];
    return c;
  endfunction

  task automatic poke(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    tbWr = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
    tbWr = 1'b0;
  endtask

  task automatic setDesc(input logic [AW-1:0] p, input logic [31:0] bufA, input logic [31:0] c);
    poke(p, bufA);
    poke(p + 8'd1, c);
  endtask

  task automatic expectFetch(input logic [31:0] a, input int l, input bit last, input bit nc);
    fetchItem_t e;
    e.a = a; e.l = l[10:0]; e.last = last; e.nc = nc;
    expQ.push_back(e);
  endtask

  task automatic goPulse(input logic [AW-1:0] p);
    @(negedge clk);
    startPtr = p; goStrobe = 1'b1;
    @(negedge clk);
    goStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!idle) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  logic [31:0] c0, c1, c2;

  initial begin
    listBase = 8'h10;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 idle", {31'd0, idle}, 32'd1);
    check("R1 errFlag", {31'd0, errFlag}, 32'd0);
    check("R1 memRd", {31'd0, memRd}, 32'd0);
    check("R1 memWr", {31'd0, memWr}, 32'd0);
    check("R1 fetchValid", {31'd0, fetchValid}, 32'd0);

    // R2 R4 R6 R7 R3: two-buffer frame then owned descriptor
    c0 = mkCtl(0, 0, 1, 0, 64);
    c1 = mkCtl(0, 0, 1, 1, 100);
    c2 = mkCtl(1, 0, 0, 1, 3);
    setDesc(8'h10, 32'h0000_1000, c0);
    setDesc(8'h12, 32'h0000_2000, c1);
    setDesc(8'h14, 32'h0000_3000, c2);
    expectFetch(32'h1000, 64, 0, 0);
    expectFetch(32'h2000, 100, 1, 1);
    goPulse(8'h10);
    waitIdle();
    check("R7 first desc owned", mem[8'h11], c0 | 32'h8000_0000);
    check("R7 later desc untouched", mem[8'h13], c1);
    check("R3 owned desc untouched", mem[8'h15], c2);
    check("R3 no error", {31'd0, errFlag}, 32'd0);
    check("R4 queue drained", expQ.size(), 32'd0);

    // R5 wrap: trap at 0x32 must not be fetched; base 0x10 now owned
    c0 = mkCtl(0, 1, 0, 1, 5);
    setDesc(8'h30, 32'h0000_4000, c0);
    setDesc(8'h32, 32'h0000_3200, mkCtl(0, 0, 0, 1, 1));
    expectFetch(32'h4000, 5, 1, 0);
    goPulse(8'h30);
    waitIdle();
    check("R5 wrapped desc written", mem[8'h31], c0 | 32'h8000_0000);
    check("R5 trap untouched", mem[8'h33], mkCtl(0, 0, 0, 1, 1));
    check("R5 no error", {31'd0, errFlag}, 32'd0);

    // R8 retry limit
    c0 = mkCtl(0, 0, 0, 1, 7);
    setDesc(8'h40, 32'h0000_5000, c0);
    setDesc(8'h42, 32'h0000_4200, mkCtl(0, 0, 0, 1, 1));
    cfgRetry = 1'b1;
    expectFetch(32'h5000, 7, 1, 0);
    goPulse(8'h40);
    waitIdle();
    cfgRetry = 1'b0;
    check("R8 retry bit, not owned", mem[8'h41], c0 | 32'h2000_0000);
    check("R8 errFlag", {31'd0, errFlag}, 32'd1);
    check("R8 idle", {31'd0, idle}, 32'd1);

    // R11 R9: go clears error, go while busy ignored, underrun
    c0 = mkCtl(0, 0, 0, 1, 9);
    setDesc(8'h50, 32'h0000_6000, c0);
    setDesc(8'h52, 32'h0000_5200, mkCtl(0, 0, 0, 1, 1));
    setDesc(8'h60, 32'h0000_6600, mkCtl(0, 0, 0, 1, 1));
    cfgUnder = 1'b1;
    expectFetch(32'h6000, 9, 1, 0);
    goPulse(8'h50);
    check("R11 errFlag cleared by go", {31'd0, errFlag}, 32'd0);
    check("R11 busy after go", {31'd0, idle}, 32'd0);
    goPulse(8'h60);
    waitIdle();
    cfgUnder = 1'b0;
    check("R9 underrun bit, not owned", mem[8'h51], c0 | 32'h1000_0000);
    check("R11 busy go ignored", mem[8'h61], mkCtl(0, 0, 0, 1, 1));
    check("R9 errFlag", {31'd0, errFlag}, 32'd1);

    // R10 exhaustion mid-frame
    c0 = mkCtl(0, 0, 0, 0, 11);
    c1 = mkCtl(1, 0, 0, 1, 2);
    setDesc(8'h70, 32'h0000_7000, c0);
    setDesc(8'h72, 32'h0000_7200, c1);
    expectFetch(32'h7000, 11, 0, 0);
    goPulse(8'h70);
    waitIdle();
    check("R10 exhaust+underrun bits", mem[8'h71], c0 | 32'h1800_0000);
    check("R10 owned desc untouched", mem[8'h73], c1);
    check("R10 errFlag", {31'd0, errFlag}, 32'd1);

    check("R4 all fetches seen", expQ.size(), 32'd0);
    check("R12 no read/write clash", rdWrClash, 32'd0);
    finish();
  end

endmodule